// File: doc/BRIEF.md
# Dual-Law Companded PCM Expander

This block takes one 8-bit companded telephony code per sample and returns the matching linear sample as 14-bit two's complement. An ADPCM encoder uses it on its input and a decoder on its reconstructed output. A per-sample select input chooses either A-law or mu-law. The block first strips the bit inversion that transmission practice applies to each law. It then splits the code into a sign flag and a 7-bit magnitude index (3-bit segment, 4-bit step). The index selects a magnitude from lookup tables that the design builds itself from the segment/step formula. Finally the sign is applied.

The block stores no samples. Each valid input gives one registered output a clock later. The data outputs keep their last value while no new sample arrives. A-law magnitudes come out doubled, so both laws share one 14-bit signed range. A second output carries the same value sign-extended for a 16-bit datapath.

Top module: `pcm_law_expander`

## Requirements
- R1: The code is XORed with 0x55 when `law_sel` is 1 (A-law) and with 0x7F when `law_sel` is 0 (mu-law), before any other decoding.
- R2: After R1, bit 7 set means a non-negative output equal to the magnitude, and bit 7 clear means the two's-complement negation of the magnitude.
- R3: In mu-law, with segment s = bits 6:4 and step m = bits 3:0 of the unmasked code, the magnitude is ((2m+33)·2^s) − 33. Its range is 0 to 8031.
- R4: In A-law, the magnitude is 2·(2m+1) for s = 0 and 2·((2m+33)·2^(s−1)) for s > 0. It is therefore always even and at most 8064.
- R5: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the outputs then carry that sample.
- R6: While `in_valid` is low, `lin14` and `lin16` keep their previous value.
- R7: `lin16` always equals `lin14` sign-extended.
- R8: During reset `out_valid`, `lin14` and `lin16` are zero.
- R9: The law is taken from `law_sel` in the same cycle as each code, so back-to-back samples of different laws are each decoded under their own law.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Code present this cycle |
| law_sel | input | 1 | 1 = A-law, 0 = mu-law |
| code | input | 8 | Companded code as transmitted |
| out_valid | output | 1 | Linear result present |
| lin14 | output | 14 | Linear sample, two's complement |
| lin16 | output | 16 | Linear sample sign-extended |

## Verification
A new code can be accepted and decoded under one law in the same cycle that the result of the previous code, decoded under the other law, is being presented. A sweep that toggles `law_sel` on every sample, with no gaps, provokes this case. Idle cycles are mixed in so that holds land next to law switches. The bench compares every output cycle against magnitudes it computes from the 16-bit-scale decode formulas, divided back down. A result held or mixed from the wrong law or the wrong sample therefore shows up as a mismatch in the cycle it appears.

// File: rtl/pcm_exp_pkg.sv
package pcm_exp_pkg;
  localparam int CODE_W = 8;
  localparam int IDX_W  = CODE_W - 1;
  localparam int LIN_W  = 14;
  localparam int MAG_W  = LIN_W - 1;
  localparam int N_IDX  = 1 << IDX_W;

  typedef enum logic {LAW_MU = 1'b0, LAW_A = 1'b1} law_e;

  localparam logic [CODE_W-1:0] INV_A  = 8'h55;
  localparam logic [CODE_W-1:0] INV_MU = 8'h7F;

  typedef struct packed {
    logic             pos;
    logic [IDX_W-1:0] idx;
  } split_t;

  // mu-law magnitude at native 14-bit scale
  function automatic logic [15:0] mu_mag(input logic [IDX_W-1:0] idx);
    logic [15:0] base;
    base = {11'd0, idx[3:0], 1'b0} + 16'd33;
    return (base << idx[6:4]) - 16'd33;
  endfunction

  // A-law magnitude, already doubled to the common range
  function automatic logic [15:0] a_mag(input logic [IDX_W-1:0] idx);
    logic [15:0] base;
    if (idx[6:4] == 3'd0) begin
      base = {11'd0, idx[3:0], 1'b1};
    end else begin
      base = ({11'd0, idx[3:0], 1'b0} + 16'd33) << (idx[6:4] - 3'd1);
    end
    return {base[14:0], 1'b0};
  endfunction
endpackage

// File: rtl/pcm_exp_unmask.sv
module pcm_exp_unmask
  import pcm_exp_pkg::*;
(
  input  logic              law_a,
  input  logic [CODE_W-1:0] code,
  output split_t            fields
);
  logic [CODE_W-1:0] inv_pat;
  logic [CODE_W-1:0] plain;

  always_comb begin
    inv_pat = law_a ? INV_A : INV_MU;
    plain   = code ^ inv_pat;
    fields.pos = plain[CODE_W-1];
    fields.idx = plain[IDX_W-1:0];
  end
endmodule

// File: rtl/pcm_exp_mag_lut.sv
module pcm_exp_mag_lut
  import pcm_exp_pkg::*;
(
  input  logic             law_a,
  input  logic [IDX_W-1:0] idx,
  output logic [MAG_W-1:0] mag
);
  logic [MAG_W-1:0] mu_tab [N_IDX];
  logic [MAG_W-1:0] a_tab  [N_IDX];

  for (genvar g = 0; g < N_IDX; g++) begin : g_tab
    localparam logic [15:0] MU_V = mu_mag(IDX_W'(g));
    localparam logic [15:0] A_V  = a_mag(IDX_W'(g));
    assign mu_tab[g] = MU_V[MAG_W-1:0];
    assign a_tab[g]  = A_V[MAG_W-1:0];
  end

  always_comb begin
    mag = law_a ? a_tab[idx] : mu_tab[idx];
  end
endmodule

// File: rtl/pcm_exp_sign_reg.sv
module pcm_exp_sign_reg
  import pcm_exp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             pos,
  input  logic [MAG_W-1:0] mag,
  output logic             out_valid,
  output logic [LIN_W-1:0] lin
);
  logic [LIN_W-1:0] signed_val;
  logic [LIN_W-1:0] lin_d, lin_q;
  logic             vld_d, vld_q;

  always_comb begin
    signed_val = pos ? {1'b0, mag} : (~{1'b0, mag} + LIN_W'(1));
    lin_d      = in_valid ? signed_val : lin_q;
    vld_d      = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q <= '0;
      vld_q <= 1'b0;
    end else begin
      lin_q <= lin_d;
      vld_q <= vld_d;
    end
  end

  assign lin       = lin_q;
  assign out_valid = vld_q;

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(lin));
  assert_neg_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pos && mag != '0) |=> lin[LIN_W-1]);
  assert_pos_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pos) |=> !lin[LIN_W-1]);
endmodule

// File: rtl/pcm_law_expander.sv
module pcm_law_expander
  import pcm_exp_pkg::*;
#(
  parameter int EXT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              law_sel,
  input  logic [CODE_W-1:0] code,
  output logic              out_valid,
  output logic [LIN_W-1:0]  lin14,
  output logic [EXT_W-1:0]  lin16
);
  localparam int PAD_W = EXT_W - LIN_W;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  split_t           fields;
  logic [MAG_W-1:0] mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pcm_exp_unmask u_unmask (
    .law_a  (law_sel),
    .code   (code),
    .fields (fields)
  );

  pcm_exp_mag_lut u_lut (
    .law_a (law_sel),
    .idx   (fields.idx),
    .mag   (mag)
  );

  pcm_exp_sign_reg u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .pos       (fields.pos),
    .mag       (mag),
    .out_valid (out_valid),
    .lin       (lin14)
  );

  if (PAD_W > 0) begin : g_ext
    assign lin16 = {{PAD_W{lin14[LIN_W-1]}}, lin14};
  end else begin : g_noext
    assign lin16 = lin14[EXT_W-1:0];
  end

  assert_a_even_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && law_sel == LAW_A) |=> !lin14[0]);
  assert_mu_mag_range_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && law_sel == LAW_MU && !fields.pos) |-> mag <= MAG_W'(8031));
  assert_mu_zero_code_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && law_sel == LAW_MU && code == 8'hFF) |=> lin14 == '0);
  assert_ext_match_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> $signed(lin16) == EXT_W'($signed(lin14)));
endmodule

// File: tb/tb_pcm_law_expander.sv
module tb_pcm_law_expander;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        law_sel;
  logic [7:0]  code;
  logic        out_valid;
  logic [13:0] lin14;
  logic [15:0] lin16;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit exp_v = 1'b0;
  int exp_lin = 0;
  string exp_req = "R8";

  always #2 clk = ~clk;

  pcm_law_expander #(.EXT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .law_sel(law_sel),
    .code(code), .out_valid(out_valid), .lin14(lin14), .lin16(lin16)
  );

  // Reference: 16-bit-scale decode, scaled down by 4 (A-law result is then doubled magnitude)
  function automatic int ref_lin(input bit a, input int c);
    int x, s, m, mag;
    x = (c ^ (a ? 'h55 : 'h7F)) & 'hFF;   // R1
    s = (x >> 4) & 7;
    m = x & 15;
    if (!a) mag = (((m << 3) + 132) << s) - 132;          // R3
    else if (s == 0) mag = (m << 4) + 8;                  // R4
    else mag = ((m << 4) + 264) << (s - 1);               // R4
    mag = mag / 4;
    return ((x & 128) != 0) ? mag : -mag;                 // R2
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_out();
    chk("R5 valid", int'(out_valid), int'(exp_v));
    chk(exp_req, int'($signed(lin14)), exp_lin);
    chk("R7 ext", int'($signed(lin16)), exp_lin);
  endtask

  task automatic step(input bit v, input bit a, input int c, input string req);
    @(negedge clk);
    check_out();
    in_valid = v;
    law_sel  = a;
    code     = c[7:0];
    exp_v    = v;
    if (v) begin
      exp_lin = ref_lin(a, c);
      exp_req = req;
    end else begin
      exp_req = "R6 hold";
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; law_sel = 1'b0; code = 8'h00;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 valid", int'(out_valid), 0);
    chk("R8 lin14", int'(lin14), 0);
    chk("R8 lin16", int'(lin16), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // idle after reset: R6 holds zero
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0, "R6");
    // exhaustive mu-law, back to back: R1 R2 R3
    for (int c = 0; c < 256; c++) step(1'b1, 1'b0, c, "R1 R2 R3 mu");
    // exhaustive A-law, back to back: R1 R2 R4
    for (int c = 0; c < 256; c++) step(1'b1, 1'b1, c, "R1 R2 R4 A");
    // alternating law per sample with idle gaps: R9, R6
    for (int i = 0; i < 1024; i++) begin
      if (i % 5 == 4) step(1'b0, i[0], (i * 91) & 255, "R6");
      else step(1'b1, i[0], (i * 37 + i / 256) & 255, "R9 mixed");
    end
    // boundaries: mu zero codes, A extremes
    step(1'b1, 1'b0, 'hFF, "R3 mu +0");
    step(1'b1, 1'b0, 'h7F, "R3 mu -0");
    step(1'b1, 1'b0, 'h80, "R3 mu max");
    step(1'b1, 1'b1, 'hAA, "R4 A max");
    step(1'b1, 1'b1, 'h55, "R4 A min neg");
    step(1'b0, 1'b0, 0, "R6");
    step(1'b0, 1'b1, 'h12, "R6");
    @(negedge clk);
    check_out();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule